// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block gathers performance statistics for a memory subsystem. A set of sixteen general counters each watch one line of a 64-bit vector of single-cycle event pulses; the line is picked by a 6-bit event code. Alongside them runs a 56-bit cycle counter. All of it sits behind a simple 32-bit register bus: an address, a write strobe with write data, a read strobe, and read data that arrives on the following cycle.

Software starts, stops or clears the whole bank through one control word. It assigns events to counters through packed select words that each hold four one-byte slots. It seeds a counter by first naming the counter in a test-select word and then writing the value. When a general counter rolls over, a sticky overflow flag is raised. Enabled flags drive a level interrupt. Enables are changed through separate write-one-to-set and write-one-to-clear words. Flags are dropped through a write-one-to-clear word.

The register bus has no back-pressure. Every access completes in the cycle its strobe is sampled, so the block has no valid/ready handshake.

Top module: `mc_evt_counter_bank`

## Requirements
- R1: After reset every counter, the cycle counter, every select word, every enable and every overflow flag is zero, the bank is stopped (control word 0x00 reads 0) and `irq` is low.
- R2: A write to the control word 0x00 with bit 0 set starts the bank and with bit 1 set stops it; if both are set, stop wins. Bit 2 clears all sixteen counters and the cycle counter to zero. Control bit 0 reads back the running state.
- R3: Counter n takes its slot from select word 0x0C + n/4, in bits 8*(n mod 4)+7 down to 8*(n mod 4). Slot bit 7 enables the counter and slot bits 5:0 give the event code. Select words read back as written.
- R4: Once started, an enabled counter adds exactly one on each clock in which `evt_pulse[code]` is high. A stopped bank or a cleared enable bit leaves the counter unchanged whatever the pulses do.
- R5: The 32-bit value of counter n is read at word 0x10 + n.
- R6: The 56-bit cycle counter adds one on every clock while the bank is started. Word 0x03 returns bits 55:32 in its low 24 bits, and word 0x04 returns bits 31:0.
- R7: A read of word 0x03 captures bits 31:0 as they stand at that read. The next read of word 0x04 returns that captured value even if the counter has moved since. Later reads of 0x04 return the live value.
- R8: Writing 19 + n (n from 0 to 15) to the test-select word 0x01 picks counter n. A write to the preload word 0x02 then loads that counter with the written data. With any other test-select value, preload writes change no counter.
- R9: When counter n steps from 0xFFFFFFFF to 0, bit 8 + n of the overflow-status word 0x09 is set and the counter reads 0. Bits 7:0 and 31:24 of the status word read zero.
- R10: A 1 written to bit b of word 0x05 sets enable b, and a 1 written to bit b of word 0x06 clears it. Bits written with 0 are unchanged. Word 0x07 reads the enables, with bits 7:0 always zero.
- R11: A 1 written to bit b of word 0x08 clears overflow flag b. Flags whose bits are written with 0 are unchanged.
- R12: `irq` is high exactly when some overflow flag and its enable are both set.
- R13: Data for a read strobe sampled at a clock edge appears on `bus_rdata` after that edge. A write takes effect at the edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_pulse | input | 64 | Event pulses, indexed by event code |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Every result has a fixed latency of one edge. A write or an event pulse sampled at an edge changes a counter, flag or enable at that edge, and `irq` follows the flops combinationally. Read data shows up one edge after its strobe. The bench drives all inputs on the falling edge and samples `bus_rdata` and `irq` on the next falling edge, so each check sits half a cycle after the edge it depends on. The cycle-counter checks count these edges exactly: the start edge adds nothing, the stop edge still adds one, and a high-word read captures the value held before its own edge.

// File: rtl/mcecb_pkg.sv
package mcecb_pkg;
  localparam int REG_AW   = 6;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 6;
  localparam int EVT_W    = 1 << CODE_W;
  localparam int STAT_LSB = 8;

  localparam logic [REG_AW-1:0] A_CTRL    = 6'h00;
  localparam logic [REG_AW-1:0] A_TSEL    = 6'h01;
  localparam logic [REG_AW-1:0] A_PRELOAD = 6'h02;
  localparam logic [REG_AW-1:0] A_CYC_HI  = 6'h03;
  localparam logic [REG_AW-1:0] A_CYC_LO  = 6'h04;
  localparam logic [REG_AW-1:0] A_IEN_SET = 6'h05;
  localparam logic [REG_AW-1:0] A_IEN_CLR = 6'h06;
  localparam logic [REG_AW-1:0] A_IEN     = 6'h07;
  localparam logic [REG_AW-1:0] A_OVF_CLR = 6'h08;
  localparam logic [REG_AW-1:0] A_OVF     = 6'h09;
  localparam logic [REG_AW-1:0] A_EVSEL0  = 6'h0C;
  localparam logic [REG_AW-1:0] A_CTR0    = 6'h10;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_CLEAR = 2;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } evsel_t;
endpackage

// File: rtl/mcecb_ctrl.sv
module mcecb_ctrl
  import mcecb_pkg::*;
#(
  parameter int NUM_CTR   = 16,
  parameter int TSEL_BASE = 19,
  parameter int NUM_SELW  = (NUM_CTR + 3) / 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [REG_AW-1:0]                bus_addr,
  input  logic                             bus_we,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic                             run,
  output logic                             clr_all,
  output logic [NUM_SELW-1:0][DATA_W-1:0]  evsel_words,
  output logic [DATA_W-1:0]                tsel,
  output logic [NUM_CTR-1:0]               ld_vec,
  output logic [DATA_W-1:0]                ld_val,
  output logic [NUM_CTR-1:0]               ien_set,
  output logic [NUM_CTR-1:0]               ien_clr,
  output logic [NUM_CTR-1:0]               ovf_clr
);
  logic              ctrl_wr, pre_wr, sel_ok;
  logic [DATA_W-1:0] tsel_off;

  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign pre_wr   = bus_we && (bus_addr == A_PRELOAD);
  assign clr_all  = ctrl_wr && bus_wdata[CB_CLEAR];
  assign tsel_off = tsel - DATA_W'(TSEL_BASE);
  assign sel_ok   = (tsel >= DATA_W'(TSEL_BASE)) && (tsel_off < DATA_W'(NUM_CTR));
  assign ld_val   = bus_wdata;

  assign ien_set = (bus_we && bus_addr == A_IEN_SET) ? bus_wdata[STAT_LSB +: NUM_CTR] : '0;
  assign ien_clr = (bus_we && bus_addr == A_IEN_CLR) ? bus_wdata[STAT_LSB +: NUM_CTR] : '0;
  assign ovf_clr = (bus_we && bus_addr == A_OVF_CLR) ? bus_wdata[STAT_LSB +: NUM_CTR] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else if (ctrl_wr) begin
      if (bus_wdata[CB_STOP])       run <= 1'b0;
      else if (bus_wdata[CB_START]) run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 tsel <= '0;
    else if (bus_we && bus_addr == A_TSEL)      tsel <= bus_wdata;
  end

  for (genvar w = 0; w < NUM_SELW; w++) begin : g_selw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        evsel_words[w] <= '0;
      else if (bus_we && bus_addr == A_EVSEL0 + REG_AW'(w))
        evsel_words[w] <= bus_wdata;
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ld
    assign ld_vec[n] = pre_wr && sel_ok && (tsel_off == DATA_W'(n));
  end
endmodule

// File: rtl/mcecb_counter.sv
module mcecb_counter
  import mcecb_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  evsel_t           sel,
  input  logic [EVT_W-1:0] evt,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  output logic [CTR_W-1:0] count,
  output logic             wrap
);
  logic hit;

  assign hit  = run && sel.en && evt[sel.code];
  assign wrap = hit && !clr && !load && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (load)  count <= load_val;
    else if (hit)   count <= count + CTR_W'(1);
  end
endmodule

// File: rtl/mcecb_cycle.sv
module mcecb_cycle #(
  parameter int CYC_W = 56,
  parameter int LO_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [CYC_W-1:0] cyc,
  output logic [LO_W-1:0]  shadow,
  output logic             pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cyc <= '0;
    else if (clr) cyc <= '0;
    else if (run) cyc <= cyc + CYC_W'(1);
  end

  // a high-half read freezes the low half for the read that follows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      pend   <= 1'b0;
    end else if (rd_hi) begin
      shadow <= cyc[LO_W-1:0];
      pend   <= 1'b1;
    end else if (rd_lo || clr) begin
      pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/mcecb_ovf.sv
module mcecb_ovf #(
  parameter int NUM_CTR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic [NUM_CTR-1:0] stat_clr,
  input  logic [NUM_CTR-1:0] en_set,
  input  logic [NUM_CTR-1:0] en_clr,
  output logic [NUM_CTR-1:0] stat,
  output logic [NUM_CTR-1:0] ien,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      ien  <= '0;
    end else begin
      stat <= (stat & ~stat_clr) | wrap;
      ien  <= (ien | en_set) & ~en_clr;
    end
  end

  assign irq = |(stat & ien);
endmodule

// File: rtl/mc_evt_counter_bank.sv
module mc_evt_counter_bank
  import mcecb_pkg::*;
#(
  parameter int NUM_CTR   = 16,
  parameter int CTR_W     = 32,
  parameter int CYC_W     = 56,
  parameter int TSEL_BASE = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       evt_pulse,
  output logic              irq
);
  localparam int NUM_SELW = (NUM_CTR + 3) / 4;
  localparam int IDX_W    = $clog2(NUM_CTR);
  localparam int SELI_W   = (NUM_SELW > 1) ? $clog2(NUM_SELW) : 1;
  localparam int HI_W     = CYC_W - DATA_W;

  logic                            run, clr_all;
  logic [NUM_SELW-1:0][DATA_W-1:0] evsel_words;
  logic [DATA_W-1:0]               tsel, ld_val;
  logic [NUM_CTR-1:0]              ld_vec, ien_set, ien_clr, ovf_clr;
  logic [NUM_CTR-1:0]              wrap, ovf_stat, ien_q;
  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt;
  logic [CYC_W-1:0]                cyc_val;
  logic [DATA_W-1:0]               cyc_shadow, rd_mux;
  logic                            cyc_pend;
  logic [REG_AW-1:0]               ctr_off, sel_off;

  mcecb_ctrl #(.NUM_CTR(NUM_CTR), .TSEL_BASE(TSEL_BASE), .NUM_SELW(NUM_SELW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .run(run), .clr_all(clr_all),
    .evsel_words(evsel_words), .tsel(tsel), .ld_vec(ld_vec), .ld_val(ld_val),
    .ien_set(ien_set), .ien_clr(ien_clr), .ovf_clr(ovf_clr)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic [7:0] slot;
    evsel_t     sel;
    assign slot = evsel_words[n / 4][8 * (n % 4) +: 8];
    assign sel  = '{en: slot[7], code: slot[CODE_W-1:0]};

    mcecb_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_all), .sel(sel),
      .evt(evt_pulse), .load(ld_vec[n]), .load_val(ld_val[CTR_W-1:0]),
      .count(cnt[n]), .wrap(wrap[n])
    );
  end

  mcecb_cycle #(.CYC_W(CYC_W), .LO_W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_all),
    .rd_hi(bus_re && bus_addr == A_CYC_HI),
    .rd_lo(bus_re && bus_addr == A_CYC_LO),
    .cyc(cyc_val), .shadow(cyc_shadow), .pend(cyc_pend)
  );

  mcecb_ovf #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .stat_clr(ovf_clr),
    .en_set(ien_set), .en_clr(ien_clr), .stat(ovf_stat), .ien(ien_q), .irq(irq)
  );

  assign ctr_off = bus_addr - A_CTR0;
  assign sel_off = bus_addr - A_EVSEL0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr >= A_CTR0 && ctr_off < REG_AW'(NUM_CTR)) begin
      rd_mux = DATA_W'(cnt[ctr_off[IDX_W-1:0]]);
    end else if (bus_addr >= A_EVSEL0 && sel_off < REG_AW'(NUM_SELW)) begin
      rd_mux = evsel_words[sel_off[SELI_W-1:0]];
    end else begin
      case (bus_addr)
        A_CTRL:   rd_mux = DATA_W'(run);
        A_TSEL:   rd_mux = tsel;
        A_CYC_HI: rd_mux = DATA_W'(cyc_val[CYC_W-1 -: HI_W]);
        A_CYC_LO: rd_mux = cyc_pend ? cyc_shadow : cyc_val[DATA_W-1:0];
        A_IEN:    rd_mux = DATA_W'(ien_q) << STAT_LSB;
        A_OVF:    rd_mux = DATA_W'(ovf_stat) << STAT_LSB;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mc_evt_counter_bank_chk.sv
module mc_evt_counter_bank_chk
  import mcecb_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 32,
  parameter int CYC_W   = 56
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [REG_AW-1:0]             bus_addr,
  input logic                          bus_we,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic                          run,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt,
  input logic [CYC_W-1:0]              cyc,
  input logic [NUM_CTR-1:0]            ovf_stat,
  input logic [NUM_CTR-1:0]            ien,
  input logic                          irq
);
  logic clr_wr;
  assign clr_wr = bus_we && bus_addr == A_CTRL && bus_wdata[CB_CLEAR];

  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && bus_wdata[CB_STOP]) |=> !run);

  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0 && cyc == '0));

  assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_we) |=> $stable(cnt));

  assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr_wr) |=> cyc == $past(cyc) + CYC_W'(1));

  assert_enable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IEN_CLR) |=> ((ien & $past(bus_wdata[STAT_LSB +: NUM_CTR])) == '0));

  assert_irq_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IEN_CLR && (&bus_wdata[STAT_LSB +: NUM_CTR])) |=> !irq);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wrap
    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_stat[i]) |-> ($past(cnt[i]) == '1 && cnt[i] == '0));
  end
endmodule

bind mc_evt_counter_bank mc_evt_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .CYC_W(CYC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .run(run), .cnt(cnt), .cyc(cyc_val),
  .ovf_stat(ovf_stat), .ien(ien_q), .irq(irq)
);

// File: tb/mc_evt_counter_bank_tb_top.sv
module mc_evt_counter_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] A_CTRL = 6'h00, A_TSEL = 6'h01, A_PRELOAD = 6'h02,
                         A_CYC_HI = 6'h03, A_CYC_LO = 6'h04, A_IEN_SET = 6'h05,
                         A_IEN_CLR = 6'h06, A_IEN = 6'h07, A_OVF_CLR = 6'h08,
                         A_OVF = 6'h09, A_EVSEL0 = 6'h0C, A_CTR0 = 6'h10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] evt_pulse = '0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_cnt [16];
  logic [31:0] sel_word [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_evt_counter_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] slot_of(input int n);
    return sel_word[n / 4][8 * (n % 4) +: 8];
  endfunction

  function automatic logic hit_of(input int n, input logic [63:0] ev);
    logic [7:0] s = slot_of(n);
    return s[7] && ev[s[5:0]];
  endfunction

  task automatic check_all_counters(input string req);
    logic [31:0] v;
    for (int n = 0; n < 16; n++) begin
      rd(A_CTR0 + 6'(n), v);
      check(req, v, exp_cnt[n]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] ev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(A_CTRL, v);   check("R1 ctrl", v, 0);
    rd(A_IEN, v);    check("R1 enables", v, 0);
    rd(A_OVF, v);    check("R1 status", v, 0);
    rd(A_CYC_HI, v); check("R1 cycle hi", v, 0);
    rd(A_CYC_LO, v); check("R1 cycle lo", v, 0);
    rd(A_EVSEL0, v); check("R1 select", v, 0);
    for (int n = 0; n < 16; n++) exp_cnt[n] = 0;
    check_all_counters("R1 R5 counter");

    // R2 start and stop together: stop wins
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); check("R2 stop wins", v, 0);

    // R6 cycle counting: start edge adds nothing, stop edge adds one
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); check("R2 running", v, 1);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h2);
    rd(A_CYC_HI, v); check("R6 cycle hi", v, 0);
    rd(A_CYC_LO, v); check("R6 cycle lo", v, 11);

    // R7 shadow of the low half
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_CYC_HI, v); check("R7 hi", v, 0);
    repeat (7) @(negedge clk);
    rd(A_CYC_LO, v); check("R7 shadow lo", v, 5);
    wr(A_CTRL, 32'h2);
    rd(A_CYC_LO, v); check("R7 live lo", v, 15);

    // R3 R4 R5 random selects and random pulses
    wr(A_CTRL, 32'h4);
    for (int w = 0; w < 4; w++) begin
      sel_word[w] = $urandom;
      wr(A_EVSEL0 + 6'(w), sel_word[w]);
    end
    for (int w = 0; w < 4; w++) begin
      rd(A_EVSEL0 + 6'(w), v); check("R3 select readback", v, sel_word[w]);
    end
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 300; i++) begin
      ev = {$urandom, $urandom};
      evt_pulse = ev;
      for (int n = 0; n < 16; n++) if (hit_of(n, ev)) exp_cnt[n] = exp_cnt[n] + 1;
      @(negedge clk);
    end
    evt_pulse = '0;
    wr(A_CTRL, 32'h2);
    check_all_counters("R3 R4 random count");

    // R4 stopped bank ignores pulses
    for (int i = 0; i < 20; i++) begin
      evt_pulse = {$urandom, $urandom};
      @(negedge clk);
    end
    evt_pulse = '0;
    check_all_counters("R4 frozen");

    // R3 directed slot: counter 5 uses word 1 byte 1, code 5
    wr(A_CTRL, 32'h4);
    for (int n = 0; n < 16; n++) exp_cnt[n] = 0;
    for (int w = 0; w < 4; w++) begin sel_word[w] = 0; wr(A_EVSEL0 + 6'(w), 0); end
    sel_word[1] = 32'h0000_8500;
    wr(A_EVSEL0 + 6'd1, sel_word[1]);
    wr(A_CTRL, 32'h1);
    evt_pulse = 64'h20; repeat (3) @(negedge clk);
    evt_pulse = 64'h40; repeat (2) @(negedge clk);
    evt_pulse = '0;
    wr(A_CTRL, 32'h2);
    exp_cnt[5] = 3;
    check_all_counters("R3 slot 5");

    // R4 disabled slot: clear the enable bit, keep the code
    sel_word[1] = 32'h0000_0500;
    wr(A_EVSEL0 + 6'd1, sel_word[1]);
    wr(A_CTRL, 32'h1);
    evt_pulse = 64'h20; repeat (4) @(negedge clk);
    evt_pulse = '0;
    wr(A_CTRL, 32'h2);
    rd(A_CTR0 + 6'd5, v); check("R4 disabled", v, 3);

    // R2 clear bit zeroes counters and cycle counter
    wr(A_CTRL, 32'h4);
    for (int n = 0; n < 16; n++) exp_cnt[n] = 0;
    check_all_counters("R2 clear");
    rd(A_CYC_LO, v); check("R2 clear cycle", v, 0);

    // R8 preload through test select
    wr(A_TSEL, 32'd22);
    wr(A_PRELOAD, 32'hFFFF_FFFE);
    wr(A_TSEL, 32'd26);
    wr(A_PRELOAD, 32'hFFFF_FFFF);
    wr(A_TSEL, 32'd0);
    wr(A_PRELOAD, 32'h0000_1234);
    wr(A_TSEL, 32'd18);
    wr(A_PRELOAD, 32'h0000_0055);
    wr(A_TSEL, 32'd35);
    wr(A_PRELOAD, 32'h0000_0077);
    wr(A_TSEL, 32'd0);
    exp_cnt[3] = 32'hFFFF_FFFE;
    exp_cnt[7] = 32'hFFFF_FFFF;
    check_all_counters("R8 preload");

    // R9 overflow of counters 3 and 7 on code 9
    wr(A_EVSEL0, 32'h8900_0000);
    wr(A_EVSEL0 + 6'd1, 32'h8900_0000);
    wr(A_CTRL, 32'h1);
    evt_pulse = 64'h200; repeat (2) @(negedge clk);
    evt_pulse = '0;
    wr(A_CTRL, 32'h2);
    rd(A_CTR0 + 6'd3, v); check("R9 counter 3 wrapped", v, 0);
    rd(A_CTR0 + 6'd7, v); check("R9 counter 7 after wrap", v, 1);
    rd(A_OVF, v); check("R9 status", v, 32'h0000_8800);
    check("R12 irq masked", 32'(irq), 0);

    // R10 R12 enables
    wr(A_IEN_SET, 32'h0000_08FF);
    rd(A_IEN, v); check("R10 enable set", v, 32'h0000_0800);
    check("R12 irq on", 32'(irq), 1);
    wr(A_IEN_CLR, 32'h0000_0800);
    rd(A_IEN, v); check("R10 enable clear", v, 0);
    check("R12 irq off", 32'(irq), 0);
    rd(A_OVF, v); check("R10 status kept", v, 32'h0000_8800);
    wr(A_IEN_SET, 32'h0000_8800);
    wr(A_IEN_SET, 32'h0000_0000);
    rd(A_IEN, v); check("R10 zero write keeps", v, 32'h0000_8800);

    // R11 write-one clear of flags
    wr(A_OVF_CLR, 32'h0000_0800);
    rd(A_OVF, v); check("R11 partial clear", v, 32'h0000_8000);
    check("R12 irq still", 32'(irq), 1);
    wr(A_OVF_CLR, 32'h0000_8000);
    rd(A_OVF, v); check("R11 full clear", v, 0);
    check("R12 irq cleared", 32'(irq), 0);

    // R13 read data lands one edge after the strobe
    bus_addr = A_CTR0 + 6'd7; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
    check("R13 read latency", bus_rdata, 1);
    @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule